// File: doc/BRIEF.md
# Ring-Protected Translation Lookaside Buffer with Page-Table Refill

This block translates 32-bit virtual addresses to physical addresses for a core that protects memory by privilege ring. Each request gives a virtual address, an access kind and the requester's current ring. The block looks up every way of a set-associative array in parallel. It returns the physical address, the rights granted and a cache mode when the access is allowed. When the access is not allowed, it returns a fault cause code instead.

Entries carry an 8-bit address-space identifier rather than a ring number. A 32-bit ring register holds four identifiers, one per ring, and an entry's ring is the slot where its identifier appears. On a miss, the block computes the address of the page-table entry from a base register and the faulting address. It reads that entry over a simple request/response memory port and installs it into the next way of a round-robin rotation. It then completes the original access from the fetched entry.

Instruction fetches and data accesses share one array. Fault codes are reported separately for each side. Ports are provided to write the ring register and the page-table base.

Top module: `tlb_ring_mmu`

## Requirements
- R1: After reset the response and memory-request outputs are low, `req_ready` is high, `fault_vaddr` is zero, the ring register holds 0x04030201 and every entry has identifier zero, so the first access to any page performs a page-table read.
- R2: A way hits only when its stored page number equals bits 31:12 of the address and its identifier is non-zero and equals one byte of the ring register. Ring n is the byte at bits 8n+7:8n, and the lowest matching byte wins. A hit answers with a one-cycle `rsp_valid` pulse one clock after the request is accepted, with no memory request.
- R3: When two or more ways hit, the cause is 17 for a fetch and 25 for a load or store.
- R4: On a miss, the block raises `mem_req_valid` with address (base | (vaddr >> 10)) & 0xFFFFFFFC. It holds both the request and the address unchanged until `mem_rsp_valid`, and it accepts no new request meanwhile.
- R5: A memory response with `mem_rsp_err` set ends the access with cause 16 for a fetch or 24 for a load or store, and installs nothing.
- R6: A good response installs an entry with physical page = PTE bits 31:12 and attribute = PTE bits 3:0. The entry's identifier is the ring-register byte selected by PTE bits 5:4. The access then completes with ring = PTE bits 5:4, the response follows the memory response by one clock, and `fault_vaddr` records the virtual address.
- R7: Refills rotate round-robin over all ways, with a counter that advances before use. The fifth refill into one set replaces the entry installed by the first.
- R8: When the entry's ring is numerically below the requester's ring, the cause is 18 for a fetch and 26 for a load or store.
- R9: Rights are reported on `rsp_rights` as bit 0 read, bit 1 write and bit 2 execute. An attribute below 12 grants read, with attribute bit 0 adding execute, bit 1 adding write, and bits 3:2 giving `rsp_cmode` (0 bypass, 1 write-back, 2 write-through). Attribute 13 grants read and write with `rsp_cmode` 3, and any other attribute grants nothing.
- R10: Access kind 0 is a load, 1 is a store, and 2 or 3 is a fetch. Fetches keep only execute, and loads and stores keep only read and write. A missing right gives cause 20 for a fetch, 28 for a load or 29 for a store. Every faulting response reports rights and cache mode as zero.
- R11: A granted access returns cause 0 and a physical address of the entry's physical page concatenated with address bits 11:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2/3 fetch |
| req_ring | input | 2 | Requester's current ring |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_cause | output | 6 | 0 when granted, else fault code |
| rsp_paddr | output | 32 | Physical address when granted |
| rsp_rights | output | 3 | {execute, write, read} granted |
| rsp_cmode | output | 2 | Cache mode of the page |
| ring_we | input | 1 | Write the ring register |
| ring_wdata | input | 32 | Four identifiers, ring 0 in the low byte |
| ptb_we | input | 1 | Write the page-table base |
| ptb_wdata | input | 32 | Page-table base value |
| mem_req_valid | output | 1 | Page-table entry read pending |
| mem_req_addr | output | 32 | Word address of the entry |
| mem_rsp_valid | input | 1 | Entry read completes |
| mem_rsp_data | input | 32 | Page-table entry |
| mem_rsp_err | input | 1 | Entry read failed |
| fault_vaddr | output | 32 | Address of the last refilled access |

## Verification
A hit answers one clock after the edge that accepts the request. A miss raises the memory request at that same point, and its answer arrives one clock after the edge that captures the memory response. The bench drives and samples on falling edges and counts falling edges from acceptance. It expects a latency of exactly 1 for a hit, 2 for a walk answered at once, and 2 plus the stall for a delayed walk. While stalling, it checks that the request address holds steady.

// File: rtl/tlb_ring_pkg.sv
package tlb_ring_pkg;
    localparam int ADDR_W    = 32;
    localparam int PAGE_BITS = 12;
    localparam int VPN_W     = ADDR_W - PAGE_BITS;
    localparam int ASID_W    = 8;
    localparam int RINGS     = 4;
    localparam int RING_W    = $clog2(RINGS);
    localparam int ATTR_W    = 4;
    localparam int CAUSE_W   = 6;

    localparam logic [CAUSE_W-1:0] C_NONE      = 6'd0;
    localparam logic [CAUSE_W-1:0] C_I_MISS    = 6'd16;
    localparam logic [CAUSE_W-1:0] C_I_MULTI   = 6'd17;
    localparam logic [CAUSE_W-1:0] C_I_PRIV    = 6'd18;
    localparam logic [CAUSE_W-1:0] C_I_PROHIB  = 6'd20;
    localparam logic [CAUSE_W-1:0] C_D_MISS    = 6'd24;
    localparam logic [CAUSE_W-1:0] C_D_MULTI   = 6'd25;
    localparam logic [CAUSE_W-1:0] C_D_PRIV    = 6'd26;
    localparam logic [CAUSE_W-1:0] C_LD_PROHIB = 6'd28;
    localparam logic [CAUSE_W-1:0] C_ST_PROHIB = 6'd29;

    localparam logic [1:0] CM_BYPASS = 2'd0;
    localparam logic [1:0] CM_WB     = 2'd1;
    localparam logic [1:0] CM_WT     = 2'd2;
    localparam logic [1:0] CM_ISO    = 2'd3;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WALK = 2'd2
    } tlb_fsm_e;
endpackage

// File: rtl/tlb_attr_decode.sv
module tlb_attr_decode
    import tlb_ring_pkg::*;
(
    input  logic [ATTR_W-1:0] attr,
    input  logic              fetch_side,
    output logic [2:0]        rights,
    output logic [1:0]        cmode
);
    logic [2:0] raw;

    always_comb begin
        raw   = 3'b000;
        cmode = CM_BYPASS;
        if (attr < 4'd12) begin
            raw[0] = 1'b1;
            raw[1] = attr[1];
            raw[2] = attr[0];
            cmode  = attr[3:2];
        end else if (attr == 4'd13) begin
            raw   = 3'b011;
            cmode = CM_ISO;
        end
        rights = fetch_side ? (raw & 3'b100) : (raw & 3'b011);
    end
endmodule

// File: rtl/tlb_ring_map.sv
module tlb_ring_map
    import tlb_ring_pkg::*;
(
    input  logic [ASID_W-1:0]       asid,
    input  logic [RINGS*ASID_W-1:0] ring_reg,
    output logic                    mapped,
    output logic [RING_W-1:0]       ring
);
    always_comb begin
        mapped = 1'b0;
        ring   = '0;
        for (int i = RINGS - 1; i >= 0; i--) begin
            if (asid != '0 && ring_reg[i*ASID_W +: ASID_W] == asid) begin
                mapped = 1'b1;
                ring   = RING_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_way.sv
module tlb_way
    import tlb_ring_pkg::*;
#(
    parameter int SETS = 4,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output tlb_entry_t       rd_entry,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_entry
);
    tlb_entry_t mem_q [SETS];
    tlb_entry_t mem_d [SETS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_entry = mem_q[rd_idx];
endmodule

// File: rtl/tlb_ring_mmu.sv
module tlb_ring_mmu
    import tlb_ring_pkg::*;
#(
    parameter int          NWAYS      = 4,
    parameter int          SETS       = 4,
    parameter logic [31:0] RING_RESET = 32'h0403_0201
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic [1:0]         req_kind,
    input  logic [RING_W-1:0]  req_ring,
    output logic               rsp_valid,
    output logic [CAUSE_W-1:0] rsp_cause,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic [2:0]         rsp_rights,
    output logic [1:0]         rsp_cmode,
    input  logic               ring_we,
    input  logic [31:0]        ring_wdata,
    input  logic               ptb_we,
    input  logic [ADDR_W-1:0]  ptb_wdata,
    output logic               mem_req_valid,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data,
    input  logic               mem_rsp_err,
    output logic [ADDR_W-1:0]  fault_vaddr
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1;

    typedef struct packed {
        tlb_fsm_e                 st;
        logic [ADDR_W-1:0]        vaddr;
        logic [1:0]               kind;
        logic [RING_W-1:0]        ring;
        logic [RINGS*ASID_W-1:0]  ring_reg;
        logic [ADDR_W-1:0]        ptbase;
        logic                     rsp_valid;
        logic [CAUSE_W-1:0]       cause;
        logic [ADDR_W-1:0]        paddr;
        logic [2:0]               rights;
        logic [1:0]               cmode;
        logic [ADDR_W-1:0]        mem_addr;
        logic [ADDR_W-1:0]        fault_va;
        logic [WAY_W-1:0]         rf_ctr;
    } ctl_t;

    ctl_t q, d;

    // request decode
    logic              is_fetch, is_store;
    logic [IDX_W-1:0]  set_idx;
    logic [VPN_W-1:0]  req_vpn;

    assign is_fetch = q.kind[1];
    assign is_store = (q.kind == 2'b01);
    assign set_idx  = q.vaddr[PAGE_BITS +: IDX_W];
    assign req_vpn  = q.vaddr[ADDR_W-1:PAGE_BITS];

    // page-table entry fields
    logic [RING_W-1:0] pte_ring;
    logic [ATTR_W-1:0] pte_attr;
    logic [VPN_W-1:0]  pte_ppn;
    tlb_entry_t        fill_entry;

    assign pte_ring   = mem_rsp_data[5:4];
    assign pte_attr   = mem_rsp_data[ATTR_W-1:0];
    assign pte_ppn    = mem_rsp_data[ADDR_W-1:PAGE_BITS];
    assign fill_entry = '{vpn:  req_vpn,
                          ppn:  pte_ppn,
                          asid: q.ring_reg[{pte_ring, 3'b000} +: ASID_W],
                          attr: pte_attr};

    // refill way selection: advance first, then use
    logic [WAY_W-1:0] rf_next;
    logic             walk_ok;

    assign rf_next = (q.rf_ctr == WAY_W'(NWAYS - 1)) ? '0 : q.rf_ctr + 1'b1;
    assign walk_ok = (q.st == ST_WALK) && mem_rsp_valid && !mem_rsp_err;

    // ways and ring resolution
    tlb_entry_t        way_rd   [NWAYS];
    logic [RING_W-1:0] way_ring [NWAYS];
    logic [NWAYS-1:0]  way_map;
    logic [NWAYS-1:0]  hit_vec;
    logic [NWAYS-1:0]  way_we;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        assign way_we[w] = walk_ok && (int'(rf_next) == w);

        tlb_way #(.SETS(SETS)) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (set_idx),
            .rd_entry (way_rd[w]),
            .wr_en    (way_we[w]),
            .wr_idx   (set_idx),
            .wr_entry (fill_entry)
        );

        tlb_ring_map u_map (
            .asid     (way_rd[w].asid),
            .ring_reg (q.ring_reg),
            .mapped   (way_map[w]),
            .ring     (way_ring[w])
        );

        assign hit_vec[w] = way_map[w] && (way_rd[w].vpn == req_vpn);
    end

    logic any_hit, multi_hit;
    assign any_hit   = |hit_vec;
    assign multi_hit = |(hit_vec & (hit_vec - 1'b1));

    tlb_entry_t        sel_entry;
    logic [RING_W-1:0] sel_ring;

    always_comb begin
        sel_entry = '0;
        sel_ring  = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (hit_vec[w]) begin
                sel_entry = way_rd[w];
                sel_ring  = way_ring[w];
            end
        end
    end

    // shared permission check for hit and refill completions
    logic [ATTR_W-1:0]  fin_attr;
    logic [RING_W-1:0]  fin_ring;
    logic [VPN_W-1:0]   fin_ppn;
    logic [2:0]         dec_rights;
    logic [1:0]         dec_cmode;
    logic               granted;
    logic [CAUSE_W-1:0] fin_cause;
    logic [ADDR_W-1:0]  fin_paddr;
    logic [2:0]         fin_rights;
    logic [1:0]         fin_cmode;

    assign fin_attr = (q.st == ST_WALK) ? pte_attr : sel_entry.attr;
    assign fin_ring = (q.st == ST_WALK) ? pte_ring : sel_ring;
    assign fin_ppn  = (q.st == ST_WALK) ? pte_ppn  : sel_entry.ppn;

    tlb_attr_decode u_dec (
        .attr       (fin_attr),
        .fetch_side (is_fetch),
        .rights     (dec_rights),
        .cmode      (dec_cmode)
    );

    always_comb begin
        if (is_fetch)      granted = dec_rights[2];
        else if (is_store) granted = dec_rights[1];
        else               granted = dec_rights[0];

        fin_cause  = C_NONE;
        fin_paddr  = '0;
        fin_rights = '0;
        fin_cmode  = '0;
        if (fin_ring < q.ring) begin
            fin_cause = is_fetch ? C_I_PRIV : C_D_PRIV;
        end else if (!granted) begin
            fin_cause = is_fetch ? C_I_PROHIB : (is_store ? C_ST_PROHIB : C_LD_PROHIB);
        end else begin
            fin_paddr  = {fin_ppn, q.vaddr[PAGE_BITS-1:0]};
            fin_rights = dec_rights;
            fin_cmode  = dec_cmode;
        end
    end

    logic [ADDR_W-1:0] pte_addr;
    assign pte_addr = (q.ptbase | (q.vaddr >> 10)) & 32'hFFFF_FFFC;

    // next-state
    always_comb begin
        d = q;
        d.rsp_valid = 1'b0;
        if (ring_we) d.ring_reg = ring_wdata;
        if (ptb_we)  d.ptbase   = ptb_wdata;

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.vaddr = req_vaddr;
                    d.kind  = req_kind;
                    d.ring  = req_ring;
                    d.st    = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (any_hit) begin
                    d.rsp_valid = 1'b1;
                    d.st        = ST_IDLE;
                    if (multi_hit) begin
                        d.cause  = is_fetch ? C_I_MULTI : C_D_MULTI;
                        d.paddr  = '0;
                        d.rights = '0;
                        d.cmode  = '0;
                    end else begin
                        d.cause  = fin_cause;
                        d.paddr  = fin_paddr;
                        d.rights = fin_rights;
                        d.cmode  = fin_cmode;
                    end
                end else begin
                    d.mem_addr = pte_addr;
                    d.st       = ST_WALK;
                end
            end
            ST_WALK: begin
                if (mem_rsp_valid) begin
                    d.rsp_valid = 1'b1;
                    d.st        = ST_IDLE;
                    if (mem_rsp_err) begin
                        d.cause  = is_fetch ? C_I_MISS : C_D_MISS;
                        d.paddr  = '0;
                        d.rights = '0;
                        d.cmode  = '0;
                    end else begin
                        d.cause    = fin_cause;
                        d.paddr    = fin_paddr;
                        d.rights   = fin_rights;
                        d.cmode    = fin_cmode;
                        d.fault_va = q.vaddr;
                        d.rf_ctr   = rf_next;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.ring_reg <= RING_RESET;
        end else begin
            q <= d;
        end
    end

    logic unused_bits;
    assign unused_bits = ^{mem_rsp_data[11:6], sel_entry.vpn, sel_entry.asid};

    assign req_ready     = (q.st == ST_IDLE);
    assign rsp_valid     = q.rsp_valid;
    assign rsp_cause     = q.cause;
    assign rsp_paddr     = q.paddr;
    assign rsp_rights    = q.rights;
    assign rsp_cmode     = q.cmode;
    assign mem_req_valid = (q.st == ST_WALK);
    assign mem_req_addr  = q.mem_addr;
    assign fault_vaddr   = q.fault_va;
endmodule

// File: rtl/tlb_ring_mmu_chk.sv
module tlb_ring_mmu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [5:0]  rsp_cause,
    input logic [2:0]  rsp_rights,
    input logic        mem_req_valid,
    input logic [31:0] mem_req_addr,
    input logic        mem_rsp_valid,
    input logic        mem_rsp_err,
    input logic [31:0] fault_vaddr
);
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);  // R2

    AST_BUSY_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);  // R4

    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));  // R4

    AST_PTE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));  // R4

    AST_FAULT_VA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && mem_rsp_valid && !mem_rsp_err) |=> $stable(fault_vaddr));  // R6

    AST_GRANT_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == 6'd0) |-> (rsp_rights != 3'b000));  // R9

    AST_FAULT_NO_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause != 6'd0) |-> (rsp_rights == 3'b000));  // R10
endmodule

bind tlb_ring_mmu tlb_ring_mmu_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_cause     (rsp_cause),
    .rsp_rights    (rsp_rights),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .fault_vaddr   (fault_vaddr)
);

// File: tb/tb_tlb_ring_mmu.sv
module tb_tlb_ring_mmu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_ring = '0;
    logic        rsp_valid;
    logic [5:0]  rsp_cause;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_rights;
    logic [1:0]  rsp_cmode;
    logic        ring_we = 1'b0;
    logic [31:0] ring_wdata = '0;
    logic        ptb_we = 1'b0;
    logic [31:0] ptb_wdata = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic [31:0] fault_vaddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_ring_mmu dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_ring(req_ring),
        .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
        .rsp_rights(rsp_rights), .rsp_cmode(rsp_cmode),
        .ring_we(ring_we), .ring_wdata(ring_wdata),
        .ptb_we(ptb_we), .ptb_wdata(ptb_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err), .fault_vaddr(fault_vaddr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic        r_walked, r_hold_bad;
    logic [31:0] r_waddr, r_pa;
    logic [5:0]  r_cause;
    logic [2:0]  r_rights;
    logic [1:0]  r_cmode;
    int          r_lat;

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, IF = 2'd2;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_ring(input logic [31:0] v);
        @(negedge clk); ring_we = 1'b1; ring_wdata = v;
        @(negedge clk); ring_we = 1'b0;
    endtask

    task automatic set_ptb(input logic [31:0] v);
        @(negedge clk); ptb_we = 1'b1; ptb_wdata = v;
        @(negedge clk); ptb_we = 1'b0;
    endtask

    // issue one access; serve the page-table read after dly stalled cycles
    task automatic access(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] ring,
                          input logic [31:0] pte, input logic perr, input int dly);
        int  waits;
        bit  done;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_ring = ring;
        @(negedge clk);
        req_valid = 1'b0;
        r_walked = 1'b0; r_hold_bad = 1'b0; r_lat = 0; r_waddr = '0;
        waits = 0; done = 0;
        while (!done) begin
            @(negedge clk);
            r_lat++;
            mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
            if (rsp_valid) begin
                r_cause = rsp_cause; r_pa = rsp_paddr;
                r_rights = rsp_rights; r_cmode = rsp_cmode;
                done = 1;
            end else begin
                if (mem_req_valid) begin
                    if (!r_walked) begin
                        r_walked = 1'b1; r_waddr = mem_req_addr;
                    end else if (mem_req_addr !== r_waddr) begin
                        r_hold_bad = 1'b1;
                    end
                    if (waits == dly) begin
                        mem_rsp_valid = 1'b1; mem_rsp_data = pte; mem_rsp_err = perr;
                    end
                    waits++;
                end
                if (r_lat > 40) begin
                    checks++; errors++;
                    $display("FAIL R2 timeout act=no_response exp=response");
                    r_cause = 6'h3f; r_pa = '0; r_rights = '0; r_cmode = '0;
                    done = 1;
                end
            end
        end
    endtask

    task automatic t_reset;
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
        check("R1 req_ready", 32'(req_ready), 32'd1);
        check("R1 fault_vaddr", fault_vaddr, 32'd0);
    endtask

    task automatic t_first_walk;
        set_ptb(32'h8000_0000);
        access(32'h0001_2345, LD, 2'd0, 32'hABCD_E007, 1'b0, 0);
        check("R1 first access walks", 32'(r_walked), 32'd1);
        check("R4 pte address", r_waddr, 32'h8000_0048);
        check("R6 walk latency", r_lat, 32'd2);
        check("R11 cause", 32'(r_cause), 32'd0);
        check("R11 paddr", r_pa, 32'hABCD_E345);
        check("R10 data side rights", 32'(r_rights), 32'h3);
        check("R9 write-back mode", 32'(r_cmode), 32'd1);
        check("R6 fault_vaddr", fault_vaddr, 32'h0001_2345);
    endtask

    task automatic t_hit;
        access(32'h0001_2ABC, LD, 2'd0, 32'h0, 1'b0, 0);
        check("R2 hit no walk", 32'(r_walked), 32'd0);
        check("R2 hit latency", r_lat, 32'd1);
        check("R11 hit paddr", r_pa, 32'hABCD_EABC);
        access(32'h0001_2000, IF, 2'd0, 32'h0, 1'b0, 0);
        check("R10 fetch cause", 32'(r_cause), 32'd0);
        check("R10 fetch rights", 32'(r_rights), 32'h4);
        access(32'h0001_2004, ST, 2'd0, 32'h0, 1'b0, 0);
        check("R11 store cause", 32'(r_cause), 32'd0);
    endtask

    task automatic t_priv;
        access(32'h0001_2000, LD, 2'd3, 32'h0, 1'b0, 0);
        check("R8 data priv", 32'(r_cause), 32'd26);
        check("R10 fault rights zero", 32'(r_rights), 32'd0);
        access(32'h0001_2000, IF, 2'd3, 32'h0, 1'b0, 0);
        check("R8 fetch priv", 32'(r_cause), 32'd18);
    endtask

    task automatic t_rights;
        // attr 5 (read+exec, write-back), ring 1
        access(32'h0002_0000, ST, 2'd1, 32'h1234_5015, 1'b0, 0);
        check("R10 store prohibited", 32'(r_cause), 32'd29);
        check("R6 install on fault walk", fault_vaddr, 32'h0002_0000);
        access(32'h0002_0010, LD, 2'd1, 32'h0, 1'b0, 0);
        check("R6 ring from pte hit", 32'(r_walked), 32'd0);
        check("R9 attr5 load rights", 32'(r_rights), 32'h1);
        access(32'h0002_0010, IF, 2'd1, 32'h0, 1'b0, 0);
        check("R9 attr5 fetch rights", 32'(r_rights), 32'h4);
        access(32'h0002_0010, LD, 2'd2, 32'h0, 1'b0, 0);
        check("R8 ring1 entry ring2 req", 32'(r_cause), 32'd26);
        // attr 13 isolate
        access(32'h0003_0040, ST, 2'd0, 32'h5550_000D, 1'b0, 0);
        check("R9 attr13 store cause", 32'(r_cause), 32'd0);
        check("R9 attr13 rights", 32'(r_rights), 32'h3);
        check("R9 attr13 mode", 32'(r_cmode), 32'd3);
        access(32'h0003_0040, IF, 2'd0, 32'h0, 1'b0, 0);
        check("R10 fetch prohibited", 32'(r_cause), 32'd20);
        // attr 14 grants nothing
        access(32'h0005_0000, LD, 2'd0, 32'h6660_000E, 1'b0, 0);
        check("R9 attr14 load prohibited", 32'(r_cause), 32'd28);
        // attr 2 bypass, attr 8 write-through
        access(32'h0006_0000, LD, 2'd0, 32'h7700_0002, 1'b0, 0);
        check("R9 attr2 rights", 32'(r_rights), 32'h3);
        check("R9 attr2 bypass", 32'(r_cmode), 32'd0);
        access(32'h0007_0000, LD, 2'd0, 32'h8800_0008, 1'b0, 0);
        check("R9 attr8 rights", 32'(r_rights), 32'h1);
        check("R9 attr8 write-through", 32'(r_cmode), 32'd2);
        access(32'h0007_0000, ST, 2'd0, 32'h0, 1'b0, 0);
        check("R10 attr8 store prohibited", 32'(r_cause), 32'd29);
    endtask

    task automatic t_walk_err;
        logic [31:0] fv;
        fv = fault_vaddr;
        access(32'h0080_2000, LD, 2'd0, 32'hDEAD_0007, 1'b1, 0);
        check("R5 data miss", 32'(r_cause), 32'd24);
        check("R5 no fault_vaddr update", fault_vaddr, fv);
        access(32'h0080_2000, IF, 2'd0, 32'hDEAD_0007, 1'b1, 0);
        check("R5 fetch miss", 32'(r_cause), 32'd16);
        check("R5 nothing installed", 32'(r_walked), 32'd1);
    endtask

    task automatic t_delayed_walk;
        access(32'h00C0_1000, LD, 2'd0, 32'hC0C0_0007, 1'b0, 3);
        check("R4 stalled pte address", r_waddr, 32'h8000_3004);
        check("R4 address held", 32'(r_hold_bad), 32'd0);
        check("R4 stalled latency", r_lat, 32'd5);
        check("R11 stalled paddr", r_pa, 32'hC0C0_0000);
    endtask

    task automatic t_zero_asid;
        set_ring(32'h0403_0200);
        access(32'h0090_2000, LD, 2'd0, 32'hAAA0_0007, 1'b0, 0);
        check("R6 access done from pte", 32'(r_cause), 32'd0);
        access(32'h0090_2000, LD, 2'd0, 32'hAAA0_0007, 1'b0, 0);
        check("R2 zero identifier never hits", 32'(r_walked), 32'd1);
        set_ring(32'h0403_0201);
    endtask

    task automatic t_multi;
        access(32'h0040_1000, LD, 2'd0, 32'h9990_0007, 1'b0, 0);
        set_ring(32'h0403_0205);
        access(32'h0040_1000, LD, 2'd0, 32'h9990_0007, 1'b0, 0);
        check("R2 unmapped identifier misses", 32'(r_walked), 32'd1);
        set_ring(32'h0405_0201);
        access(32'h0040_1000, LD, 2'd0, 32'h0, 1'b0, 0);
        check("R3 data multi-hit", 32'(r_cause), 32'd25);
        check("R3 no walk", 32'(r_walked), 32'd0);
        access(32'h0040_1000, IF, 2'd0, 32'h0, 1'b0, 0);
        check("R3 fetch multi-hit", 32'(r_cause), 32'd17);
        set_ring(32'h0403_0201);
    endtask

    task automatic t_rotate;
        for (int k = 0; k < 4; k++) begin
            access(32'h0010_3000 + (k << 16), LD, 2'd0, {20'hB0000 + 20'(k), 12'h007}, 1'b0, 0);
            check("R7 fill walk", 32'(r_walked), 32'd1);
        end
        for (int k = 0; k < 4; k++) begin
            access(32'h0010_3000 + (k << 16), LD, 2'd0, 32'h0, 1'b0, 0);
            check("R7 all ways resident", 32'(r_walked), 32'd0);
            check("R7 resident paddr", r_pa, {20'hB0000 + 20'(k), 12'h000});
        end
        access(32'h0014_3000, LD, 2'd0, 32'hB000_4007, 1'b0, 0);
        check("R7 fifth fill walks", 32'(r_walked), 32'd1);
        for (int k = 1; k < 4; k++) begin
            access(32'h0010_3000 + (k << 16), LD, 2'd0, 32'h0, 1'b0, 0);
            check("R7 younger kept", 32'(r_walked), 32'd0);
        end
        access(32'h0010_3000, LD, 2'd0, 32'hB000_0007, 1'b0, 0);
        check("R7 oldest replaced", 32'(r_walked), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R1 watchdog act=hung exp=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_walk();
        t_hit();
        t_priv();
        t_rights();
        t_walk_err();
        t_delayed_walk();
        t_zero_asid();
        t_multi();
        t_rotate();
        repeat (2) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule